// File: doc/BRIEF.md
# Reaction Timer with Millisecond Display

The block measures how quickly an operator responds to a light. A press on the start key opens a waiting period whose length, in raw clock cycles, is taken from an 8-bit switch value. When the wait ends, the red indicator comes on. At the same moment a four-digit decimal counter starts to advance once per millisecond. A press on the stop key turns the indicator off and freezes the counter, so the display holds the reaction time in milliseconds.

Both keys pass through a two-flop synchronizer and a rising-edge detector, so a key held down acts only once. A fresh start press from the idle or stopped condition clears the display and begins a new wait. The display drives four active-low seven-segment digits.

Top module: `reaction_timer`

## Requirements
- R1: A synchronous active-high `rst` puts the block in its idle condition: `led` is 2'b00 and all four digits show 0. This holds even when reset is applied while the count is running.
- R2: Each key passes through two flops and then a rising-edge detector. A key held high for any length of time gives exactly one action. A key that is high for a single clock is still seen.
- R3: Call the first rising clock edge that samples `start_key` high edge 0. Then `led[0]` goes high just after edge `delay_sw`+3, with the switch value read as an unsigned number of cycles.
- R4: While `led[0]` is high, the displayed value goes up by one every TICK_DIV clock cycles. The first increment comes TICK_DIV cycles after `led[0]` rises.
- R5: The display is a four-digit decimal counter with ripple carry between digits. Each digit stays in the range 0..9, and the count wraps from 9999 to 0000.
- R6: A stop edge while `led[0]` is high turns `led[0]` off and freezes the display. An increment that falls in the same cycle as the stop edge is discarded. The frozen value then stays fixed until the next start.
- R7: A stop edge in the idle condition or during the wait has no effect. The wait runs to its normal length.
- R8: A start edge in the idle or stopped condition clears the display to 0000 and begins a new wait. A start edge during the wait or while counting is ignored.
- R9: Each segment bus is active low, with bit 0 = segment a through bit 6 = segment g. Digits 0..9 use the lit-segment patterns 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F (hex, active high) and drive their bitwise inverse. `seg0` is the least significant digit.
- R10: `led[1]` is always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single clock (50 MHz in the target) |
| rst | input | 1 | Synchronous active-high reset |
| start_key | input | 1 | Start button, active high, asynchronous |
| stop_key | input | 1 | Stop button, active high, asynchronous |
| delay_sw | input | 8 | Wait length in clock cycles |
| seg3 | output | 7 | Thousands digit, active-low segments |
| seg2 | output | 7 | Hundreds digit, active-low segments |
| seg1 | output | 7 | Tens digit, active-low segments |
| seg0 | output | 7 | Units digit, active-low segments |
| led | output | 2 | Bit 0 red indicator, bit 1 tied low |

## Verification
Two events can land on the same clock edge: the millisecond increment and the stop edge. The bench sets the gap between the indicator rising and the stop press so that the stop edge falls exactly on a tick. The frozen value must then exclude that tick. Other gaps land between ticks, and their frozen values follow floor((gap+2)/TICK_DIV). Together these cases expose an off-by-one in either direction.

// File: rtl/rt_pkg.sv
package rt_pkg;

    localparam int NUM_DIGITS = 4;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DELAY,
        ST_TIMING,
        ST_STOPPED
    } rt_state_e;

    typedef logic [3:0] bcd_t;

    // Active-low segment pattern, bit0 = a ... bit6 = g
    function automatic logic [6:0] seg_encode(input bcd_t d);
        logic [6:0] lit;
        case (d)
            4'd0:    lit = 7'h3F;
            4'd1:    lit = 7'h06;
            4'd2:    lit = 7'h5B;
            4'd3:    lit = 7'h4F;
            4'd4:    lit = 7'h66;
            4'd5:    lit = 7'h6D;
            4'd6:    lit = 7'h7D;
            4'd7:    lit = 7'h07;
            4'd8:    lit = 7'h7F;
            4'd9:    lit = 7'h6F;
            default: lit = 7'h00;
        endcase
        return ~lit;
    endfunction

endpackage

// File: rtl/rt_keysync.sv
module rt_keysync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic key_in,
    output logic key_rise
);
    // chain[STAGES-1:0] synchronize, chain[STAGES] holds the previous value
    logic [STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-1:0], key_in};
    end

    assign key_rise = chain[STAGES-1] & ~chain[STAGES];

    // R2: a held key produces a single-cycle pulse
    assert_single_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        key_rise |=> !key_rise);

endmodule

// File: rtl/rt_tick.sv
module rt_tick #(
    parameter int DIV = 50000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run)     cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                 cnt <= cnt + CW'(1);
    end

    assign tick = run && (cnt == LAST);

    generate
        if (DIV > 1) begin : g_gap_chk
            // R4: ticks are spaced, never back to back
            assert_tick_gap_R4: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/rt_bcd_counter.sv
module rt_bcd_counter #(
    parameter int DIGITS = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   clr,
    input  logic                   inc,
    output logic [DIGITS-1:0][3:0] digits
);
    logic [DIGITS:0] carry;
    assign carry[0] = inc;

    generate
        for (genvar g = 0; g < DIGITS; g++) begin : g_digit
            logic [3:0] d_q;
            always_ff @(posedge clk) begin
                if (rst || clr)       d_q <= 4'd0;
                else if (carry[g])    d_q <= (d_q == 4'd9) ? 4'd0 : d_q + 4'd1;
            end
            assign carry[g+1] = carry[g] && (d_q == 4'd9);
            assign digits[g]  = d_q;

            // R5: each digit remains decimal
            assert_bcd_range_R5: assert property (@(posedge clk) disable iff (rst)
                d_q <= 4'd9);
        end
    endgenerate

    // R5: all-nines plus one wraps to zero
    assert_wrap_R5: assert property (@(posedge clk) disable iff (rst)
        (carry[DIGITS] && !clr) |=> (digits == '0));

endmodule

// File: rtl/reaction_timer.sv
module reaction_timer
    import rt_pkg::*;
#(
    parameter int TICK_DIV    = 50000,
    parameter int DLY_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_key,
    input  logic             stop_key,
    input  logic [DLY_W-1:0] delay_sw,
    output logic [6:0]       seg3,
    output logic [6:0]       seg2,
    output logic [6:0]       seg1,
    output logic [6:0]       seg0,
    output logic [1:0]       led
);
    rt_state_e                   state;
    logic [DLY_W-1:0]            dly_cnt;
    logic                        start_rise, stop_rise;
    logic                        tick, run, clr_digits, inc_digits;
    logic [NUM_DIGITS-1:0][3:0]  digits;

    rt_keysync #(.STAGES(SYNC_STAGES)) u_start_sync (
        .clk(clk), .rst(rst), .key_in(start_key), .key_rise(start_rise));

    rt_keysync #(.STAGES(SYNC_STAGES)) u_stop_sync (
        .clk(clk), .rst(rst), .key_in(stop_key), .key_rise(stop_rise));

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            dly_cnt <= '0;
        end else begin
            case (state)
                ST_IDLE, ST_STOPPED: begin
                    if (start_rise) begin
                        state   <= ST_DELAY;
                        dly_cnt <= '0;
                    end
                end
                ST_DELAY: begin
                    if (dly_cnt == delay_sw) state <= ST_TIMING;
                    else                     dly_cnt <= dly_cnt + DLY_W'(1);
                end
                ST_TIMING: begin
                    if (stop_rise) state <= ST_STOPPED;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign run        = (state == ST_TIMING);
    assign clr_digits = start_rise && (state == ST_IDLE || state == ST_STOPPED);
    // a tick coinciding with the stop edge is dropped
    assign inc_digits = tick && !stop_rise;

    rt_tick #(.DIV(TICK_DIV)) u_tick (
        .clk(clk), .rst(rst), .run(run), .tick(tick));

    rt_bcd_counter #(.DIGITS(NUM_DIGITS)) u_count (
        .clk(clk), .rst(rst), .clr(clr_digits), .inc(inc_digits), .digits(digits));

    assign seg0 = seg_encode(digits[0]);
    assign seg1 = seg_encode(digits[1]);
    assign seg2 = seg_encode(digits[2]);
    assign seg3 = seg_encode(digits[3]);
    assign led  = {1'b0, run};

    // R6: a stop while counting lands in the stopped state with the count held
    assert_stop_freezes_R6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_TIMING && stop_rise) |=> (state == ST_STOPPED && $stable(digits)));

    // R6: the frozen count does not move until a new start
    assert_hold_stopped_R6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_STOPPED && !start_rise) |=> $stable(digits));

    // R7: no path from the wait straight to stopped
    assert_no_early_stop_R7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DELAY) |=> (state != ST_STOPPED));

    // R8: the indicator lights on a cleared display
    assert_clear_on_light_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(led[0]) |-> (digits == '0));

endmodule

// File: tb/reaction_timer_tb.sv
module reaction_timer_tb;

    localparam int DIV = 4;
    localparam int NV  = 9;
    // columns: switch, gap to stop, expected latency, expected count,
    //          stop poke during wait, start poke while counting
    localparam int VEC [NV][6] = '{
        '{  0,     1,   4,    0, 0, 0},
        '{  5,     5,   9,    1, 0, 0},   // stop edge coincides with tick
        '{  3,    40,   7,   10, 0, 0},
        '{200,   400, 204,  100, 0, 0},
        '{  1,     4,   5,    1, 0, 0},
        '{  7,  4137,  11, 1034, 0, 0},
        '{ 50,    10,  54,    3, 1, 0},
        '{  2,    30,   6,    8, 0, 1},
        '{  0, 40010,   4,    3, 0, 0}    // passes 9999
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_key = 1'b0;
    logic       stop_key  = 1'b0;
    logic [7:0] delay_sw  = 8'd0;
    logic [6:0] seg3, seg2, seg1, seg0;
    logic [1:0] led;

    int checks   = 0;
    int failures = 0;

    always #4 clk = ~clk;

    reaction_timer #(.TICK_DIV(DIV)) u_dut (
        .clk(clk), .rst(rst), .start_key(start_key), .stop_key(stop_key),
        .delay_sw(delay_sw), .seg3(seg3), .seg2(seg2), .seg1(seg1),
        .seg0(seg0), .led(led));

    function automatic logic [6:0] seg_of(input int d);
        logic [6:0] p;
        case (d)
            0: p = 7'h3F; 1: p = 7'h06; 2: p = 7'h5B; 3: p = 7'h4F;
            4: p = 7'h66; 5: p = 7'h6D; 6: p = 7'h7D; 7: p = 7'h07;
            8: p = 7'h7F; default: p = 7'h6F;
        endcase
        return ~p;
    endfunction

    function automatic logic [27:0] disp_of(input int v);
        return {seg_of((v / 1000) % 10), seg_of((v / 100) % 10),
                seg_of((v / 10) % 10), seg_of(v % 10)};
    endfunction

    task automatic check_val(input string req, input string what,
                             input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic check_disp(input string req, input int v);
        check_val(req, "display", longint'({seg3, seg2, seg1, seg0}), longint'(disp_of(v)));
    endtask

    task automatic run_vector(input int sw, input int gap, input int lat_exp,
                              input int cnt_exp, input int poke_stop, input int poke_start);
        int lat = 0;
        @(negedge clk);
        delay_sw  = 8'(sw);
        start_key = 1'b1;
        while (lat < 1000) begin
            @(negedge clk);
            lat++;
            if (lat == 1) start_key = 1'b0;
            if (poke_stop != 0 && lat == 5) stop_key = 1'b1;
            if (poke_stop != 0 && lat == 6) stop_key = 1'b0;
            if (led[0]) break;
        end
        check_val("R3", "latency", lat, lat_exp);      // R3 wait length
        check_disp("R8", 0);                            // R8 cleared on light
        for (int i = 1; i <= gap; i++) begin
            @(negedge clk);
            if (poke_start != 0 && i == gap / 2)     start_key = 1'b1;
            if (poke_start != 0 && i == gap / 2 + 1) start_key = 1'b0;
        end
        stop_key = 1'b1;
        @(negedge clk);
        stop_key = 1'b0;
        repeat (4) @(negedge clk);
        check_val("R6", "led0 after stop", led[0], 0);
        check_disp("R6", cnt_exp);                      // R4 R5 R6 frozen count
        repeat (3 * DIV) @(negedge clk);
        check_disp("R6", cnt_exp);
        check_val("R10", "led1", led[1], 0);
    endtask

    initial begin
        #(8 * 190000);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state, R9 encoding of zero
        check_val("R1", "led after reset", led, 0);
        check_val("R9", "seg0 zero pattern", seg0, 7'h40);
        check_disp("R1", 0);

        // R7 stop in idle has no effect
        stop_key = 1'b1;
        @(negedge clk);
        stop_key = 1'b0;
        repeat (6) @(negedge clk);
        check_val("R7", "led after idle stop", led, 0);
        check_disp("R7", 0);

        // table walk: R2 R3 R4 R5 R6 R7 R8 R9
        for (int v = 0; v < NV; v++)
            run_vector(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], VEC[v][5]);

        // R2 a long-held start acts once: starts, later stop still freezes
        @(negedge clk);
        delay_sw  = 8'd0;
        start_key = 1'b1;
        repeat (30) @(negedge clk);
        check_val("R2", "led while start held", led[0], 1);
        stop_key = 1'b1;
        repeat (10) @(negedge clk);
        check_val("R2", "led after held stop", led[0], 0);
        check_disp("R2", 7);      // lit after edge 3, stop acts at edge 32: (32-3-1)/4
        start_key = 1'b0;
        stop_key  = 1'b0;
        repeat (5) @(negedge clk);

        // R1 reset while counting
        start_key = 1'b1;
        @(negedge clk);
        start_key = 1'b0;
        repeat (40) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_val("R1", "led after mid reset", led, 0);
        check_disp("R1", 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule